// File: doc/BRIEF.md
# Relative Register Operand Translator

This block is the operand-fetch stage of a processor that keeps several task contexts loaded at once. An issued instruction names its operands relative to its own context, the context it called (child) or the context that called it (parent). The block turns each such name into an absolute (frame, register) pair, reads the tagged word from a general register file of 8 frames by 16 registers, or reads an auxiliary value (program counter, child link, parent link) from a per-frame task table. It then forms the operand. A source may ask for only one sub-field of the word. That field is moved into the data field and retagged as a small integer (type FIXNUM, generation 0).

The second source may be replaced by an immediate small integer. The destination is translated into an absolute specifier but never read or field-selected. When an instruction runs inside a trap handler, the context code 3 picks one of the three absolute specifiers that were saved in the handler's trap-information word. All translation and reading happen in one cycle. The results are registered at the end of that cycle.

A tagged word is laid out as {type[22:19], gen[18:16], data[15:0]}, and FIXNUM is type code 0. A link is 4 bits wide: {valid, frame[2:0]}. A register name is 5 bits wide. When bit 4 is 0, bits 3:0 select a general register. When bit 4 is 1, bits 1:0 select an auxiliary value. An absolute specifier is 8 bits wide: {frame[2:0], name[4:0]}.

Top module: `ctx_operand_fetch`

## Requirements
- R1: Context code 0 resolves to the issuing frame, code 1 to the frame in the child link and code 2 to the frame in the parent link; the register name passes through unchanged.
- R2: A code 1 or code 2 reference whose link has valid bit 3 clear sets that slot's error output and gives an all-zero operand (or a zero destination frame and name) instead of reading any frame.
- R3: General register 0 of every frame reads as the all-zero word, even after a nonzero value was written to it.
- R4: With field select 0 (whole word), a general register operand is the stored tagged word unchanged; values come from the register file write port (frame, register, word).
- R5: Field select 1, 2 and 3 place the data, generation and type field, zero-extended, into the data field, with type FIXNUM (0) and generation 0.
- R6: Name bit 4 set reads the task table of the absolute frame. Bits 1:0 select the value: 0 gives the program counter, 1 the child link, 2 the parent link, 3 zero. The value is presented as a FIXNUM with generation 0, in the data field, zero-extended.
- R7: When the immediate enable is set, the second operand is {FIXNUM, 0, immediate}, its error output is clear, and its specifier is ignored.
- R8: Context code 3 uses the trap-information word. Name bits 1:0 select a saved specifier: 0 takes bits 7:0, 1 takes bits 15:8, 2 takes bits 23:16. A selection of 3 is an error as in R2.
- R9: The destination is translated by R1, R2 and R8 into an absolute frame and name with its own error output, and no field selection is applied to it.
- R10: Every output is registered: the results for an issue appear one cycle after it, with out_valid set. A cycle without an issue clears out_valid and keeps the other outputs unchanged. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rf_we | input | 1 | General register write enable |
| rf_wframe | input | 3 | Frame written |
| rf_wreg | input | 4 | Register written |
| rf_wdata | input | 23 | Tagged word written |
| td_we | input | 1 | Task table write enable |
| td_wframe | input | 3 | Frame whose table entry is written |
| td_wpc | input | 16 | Program counter value |
| td_wchild | input | 4 | Child link value |
| td_wparent | input | 4 | Parent link value |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_frame | input | 3 | Issuing frame |
| iss_child | input | 4 | Issuing frame's child link |
| iss_parent | input | 4 | Issuing frame's parent link |
| iss_trapinfo | input | 24 | Issuing frame's saved trap specifiers |
| sa_ctx | input | 2 | First source context code |
| sa_name | input | 5 | First source register name |
| sa_fsel | input | 2 | First source field select |
| sb_ctx | input | 2 | Second source context code |
| sb_name | input | 5 | Second source register name |
| sb_fsel | input | 2 | Second source field select |
| sb_imm_en | input | 1 | Use immediate for second source |
| sb_imm | input | 16 | Immediate value |
| d_ctx | input | 2 | Destination context code |
| d_name | input | 5 | Destination register name |
| out_valid | output | 1 | Registered results belong to an issue |
| op_a | output | 23 | First formed operand |
| op_b | output | 23 | Second formed operand |
| err_a | output | 1 | First source translation error |
| err_b | output | 1 | Second source translation error |
| dst_frame | output | 3 | Absolute destination frame |
| dst_name | output | 5 | Absolute destination register name |
| err_d | output | 1 | Destination translation error |

## Verification
Operand, error and destination results for an issue are due on the rising edge that follows it. The bench drives each issue on a falling edge and compares all outputs on the next falling edge, so exactly one register stage lies between the stimulus and the sample. Register file and task table writes take effect at the rising edge that samples them. The bench finishes each write before it issues any read, so no check depends on same-cycle forwarding. The idle check reads the outputs one cycle after a non-issuing cycle to confirm that the values held.

// File: rtl/ctxop_pkg.sv
// Shared widths, word layout and code values for the operand translator.
package ctxop_pkg;
    localparam int FRAME_W  = 3;
    localparam int NFRAMES  = 1 << FRAME_W;
    localparam int REG_W    = 4;
    localparam int NREGS    = 1 << REG_W;
    localparam int NAME_W   = REG_W + 1;
    localparam int SPEC_W   = FRAME_W + NAME_W;
    localparam int LINK_W   = FRAME_W + 1;
    localparam int NSAVED   = 3;
    localparam int TRAPI_W  = NSAVED * SPEC_W;
    localparam int DATA_W   = 16;
    localparam int TYPE_W   = 4;
    localparam int GEN_W    = 3;
    localparam int WORD_W   = TYPE_W + GEN_W + DATA_W;
    localparam logic [TYPE_W-1:0] TYPE_FIXNUM = '0;

    typedef struct packed {
        logic [TYPE_W-1:0] ty;
        logic [GEN_W-1:0]  gen;
        logic [DATA_W-1:0] data;
    } tword_t;

    typedef enum logic [1:0] {
        CTX_CUR    = 2'd0,
        CTX_CHILD  = 2'd1,
        CTX_PARENT = 2'd2,
        CTX_TRAP   = 2'd3
    } ctx_e;

    typedef enum logic [1:0] {
        F_WHOLE = 2'd0,
        F_DATA  = 2'd1,
        F_GEN   = 2'd2,
        F_TYPE  = 2'd3
    } fsel_e;

    typedef enum logic [1:0] {
        AUX_PC     = 2'd0,
        AUX_CHILD  = 2'd1,
        AUX_PARENT = 2'd2,
        AUX_NONE   = 2'd3
    } aux_e;
endpackage

// File: rtl/ctxop_xlate.sv
// Translates one relative specifier into an absolute frame and name.
// Assumes links carry a valid bit in their top position; on any error the
// absolute frame and name are forced to zero.
module ctxop_xlate
    import ctxop_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         ctx,
    input  logic [NAME_W-1:0]  name,
    input  logic [FRAME_W-1:0] cur_frame,
    input  logic [LINK_W-1:0]  child_link,
    input  logic [LINK_W-1:0]  parent_link,
    input  logic [TRAPI_W-1:0] trapinfo,
    output logic [FRAME_W-1:0] abs_frame,
    output logic [NAME_W-1:0]  abs_name,
    output logic               err
);
    logic [1:0]        saved_sel;
    logic [SPEC_W-1:0] saved_spec;

    assign saved_sel  = name[1:0];
    assign saved_spec = trapinfo[int'(saved_sel) * SPEC_W +: SPEC_W];

    // Select the frame source named by the context code.
    always_comb begin
        abs_frame = '0;
        abs_name  = '0;
        err       = 1'b0;
        unique case (ctx_e'(ctx))
            CTX_CUR: begin
                abs_frame = cur_frame;
                abs_name  = name;
            end
            CTX_CHILD: begin
                err = !child_link[LINK_W-1];
                if (!err) begin
                    abs_frame = child_link[FRAME_W-1:0];
                    abs_name  = name;
                end
            end
            CTX_PARENT: begin
                err = !parent_link[LINK_W-1];
                if (!err) begin
                    abs_frame = parent_link[FRAME_W-1:0];
                    abs_name  = name;
                end
            end
            CTX_TRAP: begin
                err = (saved_sel == 2'd3);
                if (!err) begin
                    abs_frame = saved_spec[SPEC_W-1:NAME_W];
                    abs_name  = saved_spec[NAME_W-1:0];
                end
            end
        endcase
    end

    // R2: a null child link never yields a frame
    assert_null_child_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx == CTX_CHILD && !child_link[LINK_W-1]) |-> (err && abs_frame == '0));

    // R2: a null parent link never yields a frame
    assert_null_parent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx == CTX_PARENT && !parent_link[LINK_W-1]) |-> (err && abs_frame == '0));
endmodule

// File: rtl/ctxop_gpr.sv
// General register file: NFRAMES x NREGS tagged words, one write port and
// NRD combinational read ports. Register 0 of each frame reads as zero.
// Assumes the caller never reads and writes the same word in one cycle.
module ctxop_gpr
    import ctxop_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic               clk,
    input  logic               we,
    input  logic [FRAME_W-1:0] wframe,
    input  logic [REG_W-1:0]   wreg,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [FRAME_W-1:0] rd_frame [NRD],
    input  logic [REG_W-1:0]   rd_reg   [NRD],
    output logic [WORD_W-1:0]  rd_data  [NRD]
);
    localparam int DEPTH = NFRAMES * NREGS;

    logic [WORD_W-1:0] mem [DEPTH];

    // Store a written word at its absolute address.
    always_ff @(posedge clk) begin
        if (we) mem[{wframe, wreg}] <= wdata;
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        // Read port i, with register 0 forced to zero.
        assign rd_data[i] = (rd_reg[i] == '0) ? '0 : mem[{rd_frame[i], rd_reg[i]}];
    end
endmodule

// File: rtl/ctxop_taskdb.sv
// Per-frame auxiliary table: program counter, child link, parent link.
// One write port, NRD combinational read ports, cleared by reset.
module ctxop_taskdb
    import ctxop_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [FRAME_W-1:0] wframe,
    input  logic [DATA_W-1:0]  wpc,
    input  logic [LINK_W-1:0]  wchild,
    input  logic [LINK_W-1:0]  wparent,
    input  logic [FRAME_W-1:0] rd_frame  [NRD],
    output logic [DATA_W-1:0]  rd_pc     [NRD],
    output logic [LINK_W-1:0]  rd_child  [NRD],
    output logic [LINK_W-1:0]  rd_parent [NRD]
);
    logic [DATA_W-1:0] pc_q     [NFRAMES];
    logic [LINK_W-1:0] child_q  [NFRAMES];
    logic [LINK_W-1:0] parent_q [NFRAMES];

    // Hold or update each frame's auxiliary entry.
    always_ff @(posedge clk) begin
        for (int f = 0; f < NFRAMES; f++) begin
            if (!rst_n) begin
                pc_q[f]     <= '0;
                child_q[f]  <= '0;
                parent_q[f] <= '0;
            end else if (we && wframe == FRAME_W'(f)) begin
                pc_q[f]     <= wpc;
                child_q[f]  <= wchild;
                parent_q[f] <= wparent;
            end
        end
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rd_pc[i]     = pc_q[rd_frame[i]];
        assign rd_child[i]  = child_q[rd_frame[i]];
        assign rd_parent[i] = parent_q[rd_frame[i]];
    end
endmodule

// File: rtl/ctxop_fsel.sv
// Four-way field selector: passes the whole word, or moves one field into
// the data position retagged as a FIXNUM of generation 0.
module ctxop_fsel
    import ctxop_pkg::*;
(
    input  tword_t     w_in,
    input  logic [1:0] sel,
    output tword_t     w_out
);
    // Pick the field named by sel.
    always_comb begin
        w_out.ty   = TYPE_FIXNUM;
        w_out.gen  = '0;
        w_out.data = '0;
        unique case (fsel_e'(sel))
            F_WHOLE: w_out      = w_in;
            F_DATA:  w_out.data = w_in.data;
            F_GEN:   w_out.data = DATA_W'(w_in.gen);
            F_TYPE:  w_out.data = DATA_W'(w_in.ty);
        endcase
    end
endmodule

// File: rtl/ctx_operand_fetch.sv
// Operand-fetch stage: translates two source and one destination specifier,
// reads general or auxiliary registers, applies field select or immediate,
// and registers all results one cycle after issue.
// Assumes register file and task table writes do not target words read in
// the same cycle.
module ctx_operand_fetch
    import ctxop_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rf_we,
    input  logic [FRAME_W-1:0] rf_wframe,
    input  logic [REG_W-1:0]   rf_wreg,
    input  logic [WORD_W-1:0]  rf_wdata,
    input  logic               td_we,
    input  logic [FRAME_W-1:0] td_wframe,
    input  logic [DATA_W-1:0]  td_wpc,
    input  logic [LINK_W-1:0]  td_wchild,
    input  logic [LINK_W-1:0]  td_wparent,
    input  logic               iss_valid,
    input  logic [FRAME_W-1:0] iss_frame,
    input  logic [LINK_W-1:0]  iss_child,
    input  logic [LINK_W-1:0]  iss_parent,
    input  logic [TRAPI_W-1:0] iss_trapinfo,
    input  logic [1:0]         sa_ctx,
    input  logic [NAME_W-1:0]  sa_name,
    input  logic [1:0]         sa_fsel,
    input  logic [1:0]         sb_ctx,
    input  logic [NAME_W-1:0]  sb_name,
    input  logic [1:0]         sb_fsel,
    input  logic               sb_imm_en,
    input  logic [DATA_W-1:0]  sb_imm,
    input  logic [1:0]         d_ctx,
    input  logic [NAME_W-1:0]  d_name,
    output logic               out_valid,
    output logic [WORD_W-1:0]  op_a,
    output logic [WORD_W-1:0]  op_b,
    output logic               err_a,
    output logic               err_b,
    output logic [FRAME_W-1:0] dst_frame,
    output logic [NAME_W-1:0]  dst_name,
    output logic               err_d
);
    localparam int NSRC  = 2;
    localparam int NSPEC = NSRC + 1;
    localparam int DSLOT = NSRC;

    logic [1:0]         x_ctx   [NSPEC];
    logic [NAME_W-1:0]  x_name  [NSPEC];
    logic [FRAME_W-1:0] a_frame [NSPEC];
    logic [NAME_W-1:0]  a_name  [NSPEC];
    logic               a_err   [NSPEC];
    logic [1:0]         s_fsel  [NSRC];

    logic [FRAME_W-1:0] rd_frame [NSRC];
    logic [REG_W-1:0]   rd_reg   [NSRC];
    logic [WORD_W-1:0]  gpr_word [NSRC];
    logic [DATA_W-1:0]  td_pc    [NSRC];
    logic [LINK_W-1:0]  td_child [NSRC];
    logic [LINK_W-1:0]  td_par   [NSRC];
    tword_t             raw      [NSRC];
    tword_t             formed   [NSRC];

    logic [WORD_W-1:0]  op_b_next;
    logic               err_b_next;

    assign x_ctx[0]  = sa_ctx;
    assign x_name[0] = sa_name;
    assign x_ctx[1]  = sb_ctx;
    assign x_name[1] = sb_name;
    assign x_ctx[DSLOT]  = d_ctx;
    assign x_name[DSLOT] = d_name;
    assign s_fsel[0] = sa_fsel;
    assign s_fsel[1] = sb_fsel;

    for (genvar k = 0; k < NSPEC; k++) begin : g_xl
        ctxop_xlate u_xlate (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctx         (x_ctx[k]),
            .name        (x_name[k]),
            .cur_frame   (iss_frame),
            .child_link  (iss_child),
            .parent_link (iss_parent),
            .trapinfo    (iss_trapinfo),
            .abs_frame   (a_frame[k]),
            .abs_name    (a_name[k]),
            .err         (a_err[k])
        );
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_rdaddr
        assign rd_frame[s] = a_frame[s];
        assign rd_reg[s]   = a_name[s][REG_W-1:0];
    end

    ctxop_gpr #(.NRD(NSRC)) u_gpr (
        .clk      (clk),
        .we       (rf_we),
        .wframe   (rf_wframe),
        .wreg     (rf_wreg),
        .wdata    (rf_wdata),
        .rd_frame (rd_frame),
        .rd_reg   (rd_reg),
        .rd_data  (gpr_word)
    );

    ctxop_taskdb #(.NRD(NSRC)) u_taskdb (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (td_we),
        .wframe    (td_wframe),
        .wpc       (td_wpc),
        .wchild    (td_wchild),
        .wparent   (td_wparent),
        .rd_frame  (rd_frame),
        .rd_pc     (td_pc),
        .rd_child  (td_child),
        .rd_parent (td_par)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // Choose general or auxiliary source word for slot s.
        always_comb begin
            raw[s] = '0;
            if (!a_err[s]) begin
                if (!a_name[s][NAME_W-1]) begin
                    raw[s] = tword_t'(gpr_word[s]);
                end else begin
                    raw[s].ty  = TYPE_FIXNUM;
                    raw[s].gen = '0;
                    unique case (aux_e'(a_name[s][1:0]))
                        AUX_PC:     raw[s].data = td_pc[s];
                        AUX_CHILD:  raw[s].data = DATA_W'(td_child[s]);
                        AUX_PARENT: raw[s].data = DATA_W'(td_par[s]);
                        AUX_NONE:   raw[s].data = '0;
                    endcase
                end
            end
        end

        ctxop_fsel u_fsel (
            .w_in  (raw[s]),
            .sel   (s_fsel[s]),
            .w_out (formed[s])
        );
    end

    // Replace the second source with the immediate when enabled.
    always_comb begin
        if (sb_imm_en) begin
            op_b_next  = {TYPE_FIXNUM, GEN_W'(0), sb_imm};
            err_b_next = 1'b0;
        end else begin
            op_b_next  = formed[1];
            err_b_next = a_err[1];
        end
    end

    // Register results at the end of the issue cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            op_a      <= '0;
            op_b      <= '0;
            err_a     <= 1'b0;
            err_b     <= 1'b0;
            dst_frame <= '0;
            dst_name  <= '0;
            err_d     <= 1'b0;
        end else begin
            out_valid <= iss_valid;
            if (iss_valid) begin
                op_a      <= formed[0];
                op_b      <= op_b_next;
                err_a     <= a_err[0];
                err_b     <= err_b_next;
                dst_frame <= a_frame[DSLOT];
                dst_name  <= a_name[DSLOT];
                err_d     <= a_err[DSLOT];
            end
        end
    end

    // R10: out_valid follows iss_valid by exactly one cycle
    assert_valid_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(iss_valid)));

    // R10: outputs hold through a cycle without an issue
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |=> ($stable(op_a) && $stable(op_b) && $stable(dst_name)));

    // R3: register 0 of the issuing frame yields a zero operand
    assert_zero_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && sa_ctx == CTX_CUR && sa_name == '0) |=> (op_a == '0));

    // R2: a failed translation never delivers data
    assert_err_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_a) |-> (op_a == '0));

    // R5: any partial field select delivers a FIXNUM of generation 0
    assert_field_retag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && sa_fsel != F_WHOLE) |=>
        (op_a[WORD_W-1 -: TYPE_W] == TYPE_FIXNUM && op_a[DATA_W +: GEN_W] == '0));

    // R7: an immediate second operand is error-free and FIXNUM
    assert_imm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && sb_imm_en) |=>
        (!err_b && op_b[WORD_W-1 -: TYPE_W] == TYPE_FIXNUM && op_b[DATA_W-1:0] == $past(sb_imm)));
endmodule

// File: tb/ctx_operand_fetch_bench.sv
`timescale 1ns/1ps
module ctx_operand_fetch_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rf_we;
    logic [2:0]  rf_wframe;
    logic [3:0]  rf_wreg;
    logic [22:0] rf_wdata;
    logic        td_we;
    logic [2:0]  td_wframe;
    logic [15:0] td_wpc;
    logic [3:0]  td_wchild, td_wparent;
    logic        iss_valid;
    logic [2:0]  iss_frame;
    logic [3:0]  iss_child, iss_parent;
    logic [23:0] iss_trapinfo;
    logic [1:0]  sa_ctx, sb_ctx, d_ctx, sa_fsel, sb_fsel;
    logic [4:0]  sa_name, sb_name, d_name;
    logic        sb_imm_en;
    logic [15:0] sb_imm;
    logic        out_valid, err_a, err_b, err_d;
    logic [22:0] op_a, op_b;
    logic [2:0]  dst_frame;
    logic [4:0]  dst_name;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [22:0] m_rf [128];
    logic [15:0] m_pc [8];
    logic [3:0]  m_ch [8];
    logic [3:0]  m_pa [8];

    always #5 clk = ~clk;

    ctx_operand_fetch u_ctx_operand_fetch (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Returns {err, frame[2:0], name[4:0]} for a relative specifier.
    function automatic logic [8:0] xl(input logic [1:0] c, input logic [4:0] n);
        logic [7:0] sp;
        case (c)
            2'd0: return {1'b0, iss_frame, n};
            2'd1: return iss_child[3]  ? {1'b0, iss_child[2:0], n}  : 9'h100;
            2'd2: return iss_parent[3] ? {1'b0, iss_parent[2:0], n} : 9'h100;
            default: begin
                if (n[1:0] == 2'd3) return 9'h100;
                sp = iss_trapinfo[n[1:0]*8 +: 8];
                return {1'b0, sp};
            end
        endcase
    endfunction

    function automatic logic [22:0] rdw(input logic [8:0] x, input logic [1:0] fs);
        logic [22:0] w;
        logic [2:0]  fr;
        logic [4:0]  nm;
        if (x[8]) return 23'd0;
        fr = x[7:5];
        nm = x[4:0];
        if (!nm[4]) w = (nm[3:0] == 4'd0) ? 23'd0 : m_rf[{fr, nm[3:0]}];
        else begin
            case (nm[1:0])
                2'd0: w = {7'd0, m_pc[fr]};
                2'd1: w = {19'd0, m_ch[fr]};
                2'd2: w = {19'd0, m_pa[fr]};
                default: w = 23'd0;
            endcase
        end
        case (fs)
            2'd1: return {7'd0, w[15:0]};
            2'd2: return {20'd0, w[18:16]};
            2'd3: return {19'd0, w[22:19]};
            default: return w;
        endcase
    endfunction

    task automatic wr_rf(input logic [2:0] f, input logic [3:0] r, input logic [22:0] w);
        rf_we = 1'b1; rf_wframe = f; rf_wreg = r; rf_wdata = w;
        m_rf[{f, r}] = w;
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    task automatic wr_td(input logic [2:0] f, input logic [15:0] pc,
                         input logic [3:0] ch, input logic [3:0] pa);
        td_we = 1'b1; td_wframe = f; td_wpc = pc; td_wchild = ch; td_wparent = pa;
        m_pc[f] = pc; m_ch[f] = ch; m_pa[f] = pa;
        @(negedge clk);
        td_we = 1'b0;
    endtask

    // Issue the current stimulus and check every output one cycle later.
    task automatic issue(input string ra, input string rb, input string rd);
        logic [8:0]  xa, xb, xd;
        logic [22:0] ea, eb;
        logic        eberr;
        xa = xl(sa_ctx, sa_name);
        xb = xl(sb_ctx, sb_name);
        xd = xl(d_ctx, d_name);
        ea = rdw(xa, sa_fsel);
        if (sb_imm_en) begin
            eb = {7'd0, sb_imm};
            eberr = 1'b0;
        end else begin
            eb = rdw(xb, sb_fsel);
            eberr = xb[8];
        end
        iss_valid = 1'b1;
        @(negedge clk);
        iss_valid = 1'b0;
        chk("R10", "out_valid", 32'(out_valid), 32'd1);
        chk(ra, "op_a", 32'(op_a), 32'(ea));
        chk(ra, "err_a", 32'(err_a), 32'(xa[8]));
        chk(rb, "op_b", 32'(op_b), 32'(eb));
        chk(rb, "err_b", 32'(err_b), 32'(eberr));
        chk(rd, "dst", 32'({err_d, dst_frame, dst_name}), 32'(xd));
    endtask

    function automatic string tag(input logic [1:0] c, input logic [4:0] n, input logic [1:0] fs);
        if (c == 2'd3) return "R8";
        if (n[4]) return "R6";
        if (fs != 2'd0) return "R5";
        if (n[3:0] == 4'd0) return "R3";
        return "R4";
    endfunction

    task automatic set_spec(input logic [1:0] ac, input logic [4:0] an, input logic [1:0] af,
                            input logic [1:0] bc, input logic [4:0] bn, input logic [1:0] bf,
                            input logic [1:0] dc, input logic [4:0] dn);
        sa_ctx = ac; sa_name = an; sa_fsel = af;
        sb_ctx = bc; sb_name = bn; sb_fsel = bf;
        d_ctx = dc; d_name = dn;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [22:0] held_a;
        void'($urandom(32'd20240607));
        rst_n = 1'b0; rf_we = 0; td_we = 0; iss_valid = 0;
        rf_wframe = 0; rf_wreg = 0; rf_wdata = 0;
        td_wframe = 0; td_wpc = 0; td_wchild = 0; td_wparent = 0;
        iss_frame = 0; iss_child = 0; iss_parent = 0; iss_trapinfo = 0;
        sb_imm_en = 0; sb_imm = 0;
        set_spec(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        iss_valid = 1'b1;
        @(negedge clk);
        iss_valid = 1'b0;
        // R10: reset state
        chk("R10", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R10", "reset op_a", 32'(op_a), 32'd0);
        chk("R10", "reset dst", 32'({err_d, err_a, err_b, dst_frame, dst_name}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int f = 0; f < 8; f++) begin
            for (int r = 0; r < 16; r++) wr_rf(3'(f), 4'(r), 23'($urandom));
            wr_td(3'(f), 16'($urandom), 4'($urandom), 4'($urandom));
        end

        // R3: nonzero write to register 0 still reads zero
        wr_rf(3'd5, 4'd0, 23'h7abcde);
        iss_frame = 3'd5; iss_child = 4'b1010; iss_parent = 4'b1001;
        iss_trapinfo = {8'h63, 8'hA4, 8'h2F};
        set_spec(0, 5'd0, 0, 0, 5'd7, 0, 0, 5'd3);
        issue("R3", "R4", "R9");

        // R1 with R4: child and parent reads, whole word
        set_spec(1, 5'd9, 0, 2, 5'd4, 0, 1, 5'd12);
        issue("R1", "R1", "R9");

        // R2: null child and null parent links
        iss_child = 4'b0011; iss_parent = 4'b0110;
        set_spec(1, 5'd9, 0, 2, 5'd4, 1, 2, 5'd2);
        issue("R2", "R2", "R2");

        // R8: saved specifiers and the invalid selection
        iss_child = 4'b1111; iss_parent = 4'b1000;
        set_spec(3, 5'd0, 0, 3, 5'd1, 2, 3, 5'd2);
        issue("R8", "R8", "R8");
        set_spec(3, 5'd3, 0, 3, 5'd2, 0, 3, 5'd3);
        issue("R8", "R8", "R8");

        // R5: data, generation and type selection
        set_spec(0, 5'd6, 1, 0, 5'd6, 2, 0, 5'd1);
        issue("R5", "R5", "R9");
        set_spec(1, 5'd11, 3, 2, 5'd13, 1, 0, 5'd1);
        issue("R5", "R5", "R9");

        // R6: every auxiliary selection, through child and current
        set_spec(1, 5'b10000, 0, 0, 5'b10001, 0, 0, 5'b10010);
        issue("R6", "R6", "R9");
        set_spec(0, 5'b10010, 0, 2, 5'b10011, 0, 1, 5'b10000);
        issue("R6", "R6", "R9");

        // R7: immediate ignores an erroring specifier
        iss_parent = 4'b0000;
        sb_imm_en = 1'b1; sb_imm = 16'hBEEF;
        set_spec(0, 5'd2, 0, 2, 5'd5, 3, 0, 5'd2);
        issue("R4", "R7", "R9");
        sb_imm_en = 1'b0;

        // R10: an idle cycle keeps the previous results
        held_a = op_a;
        set_spec(0, 5'd8, 0, 0, 5'd9, 0, 0, 5'd0);
        @(negedge clk);
        chk("R10", "idle out_valid", 32'(out_valid), 32'd0);
        chk("R10", "idle op_a held", 32'(op_a), 32'(held_a));

        // Random mix of specifiers, links and trap words
        for (int i = 0; i < 400; i++) begin
            logic [1:0] ac, bc, dc, af, bf;
            logic [4:0] an, bn, dn;
            iss_frame = 3'($urandom);
            iss_child = {($urandom % 4) != 0, 3'($urandom)};
            iss_parent = {($urandom % 4) != 0, 3'($urandom)};
            iss_trapinfo = 24'($urandom);
            ac = 2'($urandom); bc = 2'($urandom); dc = 2'($urandom);
            af = 2'($urandom); bf = 2'($urandom);
            an = 5'($urandom); bn = 5'($urandom); dn = 5'($urandom);
            sb_imm_en = (($urandom % 5) == 0);
            sb_imm = 16'($urandom);
            set_spec(ac, an, af, bc, bn, bf, dc, dn);
            issue(tag(ac, an, af), sb_imm_en ? "R7" : tag(bc, bn, bf), "R9");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule